// File: doc/BRIEF.md
# Stripe-Column Coding Pass Classifier

The classifier takes one four-sample column from a stripe of a bit plane and decides, for all four samples in the same cycle, which coding pass each one joins: significance propagation, magnitude refinement or clean-up. The caller names the pass being run for the column and supplies the column's magnitude bits. It also supplies the significance bits of the column to the left, of the column itself and of the column to the right, plus the refinement and visited state of the column. Two flags mark the first and the last column of a stripe. The block returns a membership mask for each pass, the decision bits to be coded, a run-length eligibility flag, and the updated significance, refinement and visited state to write back.

Vertical neighbours that belong to the stripes above and below are never considered. Within the propagation pass, a sample that turns significant is seen at once by the samples below it in the same column. The four results therefore equal those of a top-to-bottom walk of the column. Columns enter on a valid/ready stream and results leave through a one-deep output register on a second valid/ready stream. A stalled consumer holds the result. The producer sees `in_ready` low only while a result waits and `out_ready` is low.

Top module: `stripe_col_classifier`

## Requirements
- R1: After reset `out_valid` is 0. `in_ready` equals `!out_valid || out_ready`. A column accepted on an `in_valid && in_ready` edge produces its result on the outputs with `out_valid` high from the next cycle. While `out_valid && !out_ready`, every output holds its value.
- R2: With `in_first` = 1 the left-column significance is treated as all zero. With `in_last` = 1 the right-column significance is treated as all zero.
- R3: Bit i of every 4-bit vector is row i of the column, with bit 0 the top row. Row 0 has no upper neighbour and row 3 no lower neighbour: rows of adjacent stripes count as insignificant.
- R4: Pass code 0 (propagation). A sample is a member when it is insignificant on input and any of its up-to-eight neighbours is significant. An upper neighbour in the same column counts with its updated significance; a lower one counts with its input significance.
- R5: In pass code 0 each member's visited bit is set, and its significance bit is set when its magnitude bit is 1. No other state changes.
- R6: Pass code 1 (refinement). A sample is a member when it is significant and not visited. Each member's refinement bit is set; significance and visited are unchanged.
- R7: Pass code 2 (clean-up). A sample is a member when it is insignificant and not visited. Each member's significance is set when its magnitude bit is 1, and all four visited bits are cleared.
- R8: `out_rl` is 1 only in pass code 2 when the twelve significance bits after edge forcing are all zero and no visited bit of the column is set.
- R9: Each sample belongs to at most one pass. Its decision bit equals its magnitude bit when it is a member and is 0 otherwise.
- R10: Pass code 3 selects no pass: there are no members, the decision bits and `out_rl` are 0, and the state passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Column on the input is valid |
| in_ready | output | 1 | Block accepts a column this cycle |
| in_pass | input | 2 | Pass code: 0 propagation, 1 refinement, 2 clean-up, 3 none |
| in_first | input | 1 | Column is the leftmost of its stripe |
| in_last | input | 1 | Column is the rightmost of its stripe |
| in_mag | input | 4 | Magnitude bits of the column in the current plane |
| in_sig_prev | input | 4 | Significance of the left column |
| in_sig_cur | input | 4 | Significance of the column |
| in_sig_next | input | 4 | Significance of the right column |
| in_refine | input | 4 | Refinement state of the column |
| in_visited | input | 4 | Visited state of the column |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_spp | output | 4 | Propagation-pass members |
| out_mrp | output | 4 | Refinement-pass members |
| out_cup | output | 4 | Clean-up-pass members |
| out_dec | output | 4 | Decision bits of members |
| out_rl | output | 1 | Column is eligible for run-length coding |
| out_sig | output | 4 | Updated significance |
| out_refine | output | 4 | Updated refinement state |
| out_visited | output | 4 | Updated visited state |

## Verification
Every result is due exactly one cycle after its column is accepted and stays on the outputs until the consumer's handshake. The bench therefore queues a model prediction when it sees `in_valid && in_ready` at a falling edge. It pops and compares that prediction only on the falling edge where `out_valid && out_ready` holds, so random stalls on either side cannot move a comparison. A stalled cycle is also compared against the outputs of the cycle before it. `in_ready` is checked every cycle against the handshake rule.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    PASS_SPP  = 2'd0,
    PASS_MRP  = 2'd1,
    PASS_CUP  = 2'd2,
    PASS_IDLE = 2'd3
  } pass_e;
endpackage

// File: rtl/scp_edge_gate.sv
module scp_edge_gate #(
  parameter int ROWS = 4
) (
  input  logic            first_col,
  input  logic            last_col,
  input  logic [ROWS-1:0] sig_left,
  input  logic [ROWS-1:0] sig_right,
  output logic [ROWS-1:0] side_hit,
  output logic            side_zero
);
  logic [ROWS-1:0] gl, gr;

  // zero forcing at the stripe's left and right ends
  assign gl = first_col ? '0 : sig_left;
  assign gr = last_col  ? '0 : sig_right;
  assign side_zero = ~|{gl, gr};

  // per-row horizontal/diagonal window, clipped at the stripe's top and bottom
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int LO = (i > 0) ? i - 1 : i;
    localparam int HI = (i < ROWS - 1) ? i + 1 : i;
    assign side_hit[i] = (|gl[HI:LO]) | (|gr[HI:LO]);
  end
endmodule

// File: rtl/scp_pass_logic.sv
module scp_pass_logic
  import scp_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  pass_e           pass,
  input  logic [ROWS-1:0] mag,
  input  logic [ROWS-1:0] sig_cur,
  input  logic [ROWS-1:0] refine,
  input  logic [ROWS-1:0] visited,
  input  logic [ROWS-1:0] side_hit,
  input  logic            side_zero,
  output logic [ROWS-1:0] spp,
  output logic [ROWS-1:0] mrp,
  output logic [ROWS-1:0] cup,
  output logic [ROWS-1:0] dec,
  output logic [ROWS-1:0] sig_nxt,
  output logic [ROWS-1:0] ref_nxt,
  output logic [ROWS-1:0] vis_nxt,
  output logic            rl
);
  logic [ROWS-1:0] below;

  // bit i carries the input significance of row i+1; bottom row sees zero
  assign below = sig_cur >> 1;

  always_comb begin
    logic up_bit;
    logic hit;
    spp     = '0;
    mrp     = '0;
    cup     = '0;
    dec     = '0;
    sig_nxt = sig_cur;
    ref_nxt = refine;
    up_bit  = 1'b0;
    hit     = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      // upper row uses its updated state, lower row its original state
      hit = side_hit[i] | up_bit | below[i];
      unique case (pass)
        PASS_SPP: if (!sig_cur[i] && hit) begin
          spp[i] = 1'b1;
          dec[i] = mag[i];
          if (mag[i]) sig_nxt[i] = 1'b1;
        end
        PASS_MRP: if (sig_cur[i] && !visited[i]) begin
          mrp[i]     = 1'b1;
          dec[i]     = mag[i];
          ref_nxt[i] = 1'b1;
        end
        PASS_CUP: if (!sig_cur[i] && !visited[i]) begin
          cup[i] = 1'b1;
          dec[i] = mag[i];
          if (mag[i]) sig_nxt[i] = 1'b1;
        end
        default: ;
      endcase
      up_bit = sig_nxt[i];
    end
  end

  always_comb begin
    unique case (pass)
      PASS_SPP: vis_nxt = visited | spp;
      PASS_CUP: vis_nxt = '0;
      default:  vis_nxt = visited;
    endcase
  end

  assign rl = (pass == PASS_CUP) && side_zero && (sig_cur == '0) && (visited == '0);
endmodule

// File: rtl/stripe_col_classifier.sv
module stripe_col_classifier
  import scp_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_pass,
  input  logic            in_first,
  input  logic            in_last,
  input  logic [ROWS-1:0] in_mag,
  input  logic [ROWS-1:0] in_sig_prev,
  input  logic [ROWS-1:0] in_sig_cur,
  input  logic [ROWS-1:0] in_sig_next,
  input  logic [ROWS-1:0] in_refine,
  input  logic [ROWS-1:0] in_visited,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ROWS-1:0] out_spp,
  output logic [ROWS-1:0] out_mrp,
  output logic [ROWS-1:0] out_cup,
  output logic [ROWS-1:0] out_dec,
  output logic            out_rl,
  output logic [ROWS-1:0] out_sig,
  output logic [ROWS-1:0] out_refine,
  output logic [ROWS-1:0] out_visited
);
  logic [ROWS-1:0] side_hit;
  logic            side_zero;
  logic [ROWS-1:0] c_spp, c_mrp, c_cup, c_dec, c_sig, c_ref, c_vis;
  logic            c_rl;
  logic            in_fire;
  pass_e           pass_q;

  assign pass_q   = pass_e'(in_pass);
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  scp_edge_gate #(.ROWS(ROWS)) u_edge (
    .first_col (in_first),
    .last_col  (in_last),
    .sig_left  (in_sig_prev),
    .sig_right (in_sig_next),
    .side_hit  (side_hit),
    .side_zero (side_zero)
  );

  scp_pass_logic #(.ROWS(ROWS)) u_pass (
    .pass      (pass_q),
    .mag       (in_mag),
    .sig_cur   (in_sig_cur),
    .refine    (in_refine),
    .visited   (in_visited),
    .side_hit  (side_hit),
    .side_zero (side_zero),
    .spp       (c_spp),
    .mrp       (c_mrp),
    .cup       (c_cup),
    .dec       (c_dec),
    .sig_nxt   (c_sig),
    .ref_nxt   (c_ref),
    .vis_nxt   (c_vis),
    .rl        (c_rl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_spp     <= '0;
      out_mrp     <= '0;
      out_cup     <= '0;
      out_dec     <= '0;
      out_rl      <= 1'b0;
      out_sig     <= '0;
      out_refine  <= '0;
      out_visited <= '0;
    end else if (in_fire) begin
      out_valid   <= 1'b1;
      out_spp     <= c_spp;
      out_mrp     <= c_mrp;
      out_cup     <= c_cup;
      out_dec     <= c_dec;
      out_rl      <= c_rl;
      out_sig     <= c_sig;
      out_refine  <= c_ref;
      out_visited <= c_vis;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_spp) && $stable(out_mrp)
      && $stable(out_cup) && $stable(out_dec) && $stable(out_rl) && $stable(out_sig)
      && $stable(out_refine) && $stable(out_visited));

  // R9
  one_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_spp & out_mrp) | (out_spp & out_cup) | (out_mrp & out_cup)) == '0);

  // R9
  dec_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dec & ~(out_spp | out_mrp | out_cup)) == '0);

  // R5
  sig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (out_sig & $past(in_sig_cur)) == $past(in_sig_cur));

  // R7
  cup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_pass == 2'd2 |=> out_visited == '0);

  // R8
  rl_cup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rl |-> out_cup == '1);
endmodule

// File: tb/stripe_col_classifier_test.sv
module stripe_col_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [1:0] pass;
    logic       first, last;
    logic [3:0] mag, sp, sc, sn, rf, vs;
  } stim_t;

  typedef struct packed {
    logic [3:0] spp, mrp, cup, dec, sig, rf, vis;
    logic       rl;
  } res_t;

  logic clk = 0, rst_n;
  logic in_valid, in_ready, in_first, in_last, out_valid, out_ready, out_rl;
  logic [1:0] in_pass;
  logic [3:0] in_mag, in_sig_prev, in_sig_cur, in_sig_next, in_refine, in_visited;
  logic [3:0] out_spp, out_mrp, out_cup, out_dec, out_sig, out_refine, out_visited;

  int tests = 0, fails = 0;
  stim_t sq[$];
  string tq[$];
  res_t  eq[$];
  string etq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stripe_col_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pass(in_pass), .in_first(in_first), .in_last(in_last), .in_mag(in_mag),
    .in_sig_prev(in_sig_prev), .in_sig_cur(in_sig_cur), .in_sig_next(in_sig_next),
    .in_refine(in_refine), .in_visited(in_visited), .out_valid(out_valid),
    .out_ready(out_ready), .out_spp(out_spp), .out_mrp(out_mrp), .out_cup(out_cup),
    .out_dec(out_dec), .out_rl(out_rl), .out_sig(out_sig), .out_refine(out_refine),
    .out_visited(out_visited)
  );

  // sequential top-to-bottom reference walk of one column
  function automatic res_t model(stim_t s);
    res_t r;
    int p[4], n[4], w[4];
    int hit, zero;
    r = '0;
    r.rf = s.rf;
    r.vis = s.vs;
    for (int i = 0; i < 4; i++) begin
      p[i] = s.first ? 0 : int'(s.sp[i]);
      n[i] = s.last  ? 0 : int'(s.sn[i]);
      w[i] = int'(s.sc[i]);
    end
    for (int i = 0; i < 4; i++) begin
      hit = 0;
      for (int d = -1; d <= 1; d++) begin
        int k;
        k = i + d;
        if (k >= 0 && k < 4) begin
          if (p[k] != 0 || n[k] != 0) hit = 1;
          if (d != 0 && w[k] != 0) hit = 1;
        end
      end
      case (s.pass)
        2'd0: if (!s.sc[i] && hit != 0) begin
          r.spp[i] = 1; r.dec[i] = s.mag[i]; r.vis[i] = 1;
          if (s.mag[i]) w[i] = 1;
        end
        2'd1: if (s.sc[i] && !s.vs[i]) begin
          r.mrp[i] = 1; r.dec[i] = s.mag[i]; r.rf[i] = 1;
        end
        2'd2: if (!s.sc[i] && !s.vs[i]) begin
          r.cup[i] = 1; r.dec[i] = s.mag[i];
          if (s.mag[i]) w[i] = 1;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 4; i++) r.sig[i] = (w[i] != 0);
    if (s.pass == 2'd2) begin
      r.vis = '0;
      zero = 1;
      for (int i = 0; i < 4; i++)
        if (p[i] != 0 || n[i] != 0 || s.sc[i] || s.vs[i]) zero = 0;
      r.rl = (zero != 0);
    end
    return r;
  endfunction

  function automatic stim_t mk(logic [1:0] pass, logic f, logic l, logic [3:0] mag,
                               logic [3:0] sp, logic [3:0] sc, logic [3:0] sn,
                               logic [3:0] rf, logic [3:0] vs);
    stim_t s;
    s.pass = pass; s.first = f; s.last = l; s.mag = mag;
    s.sp = sp; s.sc = sc; s.sn = sn; s.rf = rf; s.vs = vs;
    return s;
  endfunction

  task automatic add(stim_t s, string tag);
    sq.push_back(s);
    tq.push_back(tag);
  endtask

  task automatic chk(string req, string tag, string what, logic [3:0] got, logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s got %b exp %b", req, tag, what, got, exp);
    end
  endtask

  task automatic apply(stim_t s);
    in_pass = s.pass; in_first = s.first; in_last = s.last; in_mag = s.mag;
    in_sig_prev = s.sp; in_sig_cur = s.sc; in_sig_next = s.sn;
    in_refine = s.rf; in_visited = s.vs;
  endtask

  initial begin
    res_t  e, snap, now;
    string et;
    logic  stalled;
    int    cycles;
    rst_n = 0; in_valid = 0; out_ready = 0;
    apply('0);

    // R2 edge forcing on both sides
    add(mk(2'd0, 1, 0, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 0, 0), "R2 left forced");
    add(mk(2'd0, 0, 1, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 0, 0), "R2 right forced");
    add(mk(2'd0, 0, 0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 0, 0), "R2 left unforced");
    add(mk(2'd2, 1, 1, 4'b0101, 4'b1111, 4'b0000, 4'b1111, 0, 0), "R2 R8 both forced rl");
    // R3 stripe boundary clipping
    add(mk(2'd0, 0, 0, 4'b0000, 4'b1000, 4'b0000, 4'b0000, 0, 0), "R3 bottom window");
    add(mk(2'd0, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 0, 0), "R3 top window");
    add(mk(2'd0, 0, 0, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 0, 0), "R3 R4 own column");
    // R4 propagation down the column
    add(mk(2'd0, 0, 0, 4'b1111, 4'b0001, 4'b0000, 4'b0000, 0, 0), "R4 cascade down");
    add(mk(2'd0, 0, 0, 4'b0000, 4'b0001, 4'b0000, 4'b0000, 0, 0), "R4 no cascade");
    add(mk(2'd0, 0, 0, 4'b1111, 4'b0000, 4'b0000, 4'b1000, 0, 0), "R4 no upward");
    add(mk(2'd0, 0, 0, 4'b1010, 4'b0100, 4'b0000, 4'b0000, 0, 4'b0000), "R5 spp state");
    // R6 refinement
    add(mk(2'd1, 0, 0, 4'b1100, 4'b0000, 4'b1010, 4'b0000, 4'b0001, 4'b0010), "R6 refine");
    // R7 clean-up
    add(mk(2'd2, 0, 0, 4'b1111, 4'b0000, 4'b0001, 4'b0000, 0, 4'b0100), "R7 cleanup");
    add(mk(2'd2, 0, 0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 4'b0010), "R8 visited blocks rl");
    add(mk(2'd2, 0, 0, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0, 4'b0000), "R8 rl set");
    add(mk(2'd2, 0, 0, 4'b0010, 4'b0000, 4'b0000, 4'b0100, 0, 4'b0000), "R8 neighbour blocks rl");
    // R10 no pass selected
    add(mk(2'd3, 0, 0, 4'b1111, 4'b1111, 4'b0101, 4'b1111, 4'b0011, 4'b1001), "R10 idle pass");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      add(stim_t'(rv[27:0]), "R9 random");
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset out_valid got %b exp 0", out_valid);
    end
    rst_n = 1;

    stalled = 0;
    snap = '0;
    cycles = 0;
    while ((sq.size() > 0 || eq.size() > 0) && cycles < WATCHDOG) begin
      @(negedge clk);
      cycles++;
      now = {out_spp, out_mrp, out_cup, out_dec, out_sig, out_refine, out_visited, out_rl};
      if (stalled) begin
        tests++;
        if (out_valid !== 1'b1 || now !== snap) begin
          fails++;
          $display("FAIL R1 stall hold got %b/%h exp 1/%h", out_valid, now, snap);
        end
      end
      out_ready = ($urandom_range(0, 3) != 0);
      if (sq.size() > 0) begin
        in_valid = ($urandom_range(0, 4) != 0);
        apply(sq[0]);
      end else begin
        in_valid = 0;
      end
      #1;
      tests++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R1 in_ready got %b exp %b", in_ready, !out_valid || out_ready);
      end
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1 unexpected result got valid exp none");
        end else begin
          e = eq.pop_front();
          et = etq.pop_front();
          chk("R4", et, "spp", out_spp, e.spp);
          chk("R6", et, "mrp", out_mrp, e.mrp);
          chk("R7", et, "cup", out_cup, e.cup);
          chk("R9", et, "dec", out_dec, e.dec);
          chk("R8", et, "rl", {3'b0, out_rl}, {3'b0, e.rl});
          chk("R5", et, "sig", out_sig, e.sig);
          chk("R6", et, "refine", out_refine, e.rf);
          chk("R5", et, "visited", out_visited, e.vis);
        end
      end
      stalled = out_valid && !out_ready;
      snap = now;
      if (in_valid && in_ready) begin
        eq.push_back(model(sq[0]));
        etq.push_back(tq[0]);
        void'(sq.pop_front());
        void'(tq.pop_front());
      end
    end
    if (cycles >= WATCHDOG) begin
      tests++; fails++;
      $display("FAIL R1 watchdog got %0d cycles exp fewer than %0d", cycles, WATCHDOG);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule